// File: doc/BRIEF.md
# Inter-Processor Message Mailbox

This block is a memory-mapped peripheral through which several processors pass 32-bit messages to each other. It holds a parameterised number of hardware queues, each a small first-in first-out store. A processor posts a message by writing the queue's message register and takes the oldest one by reading that same register. Each queue also exposes a full indication and a count of waiting messages.

A parameterised number of users (one per processor) each own an interrupt status register, an interrupt enable held through a set register and a clear register, and one interrupt output. Every queue drives two events into every user's status register: a new-message event on each accepted post, and a not-full event when a take moves a full queue to not full. Events are latched for all users whatever their enables are. Software acknowledges by writing ones to the status register. The interrupt line of a user is high while any of its status bits is also enabled. Access is through a simple single-cycle 32-bit read/write bus with read data returned on the cycle after the request.

Top module: `ipc_mailbox`

## Requirements
- R1: A read of byte offset 0x000 returns the fixed value given by parameter REV_ID (default 32'h4D42_0100).
- R2: A write to offset 0x040 + 4*m appends the 32-bit data to queue m; a read of that offset returns and removes the oldest entry, so entries come back in the order they were written.
- R3: A read of offset 0x080 + 4*m returns 1 while queue m holds DEPTH entries (default 4) and 0 otherwise.
- R4: A read of offset 0x0C0 + 4*m returns the number of entries in queue m; 0 means empty.
- R5: A write to a full queue is discarded and a read of an empty queue returns 0; in both cases the entry count is unchanged.
- R6: Status bit 2*m of every user is set by each accepted write to queue m, whatever that user's enable bits hold.
- R7: Status bit 2*m+1 of every user is set when a read takes an entry from queue m while it was full.
- R8: Writing to offset 0x104 + 0x10*u clears each status bit of user u written as 1 and leaves bits written as 0; a bit written as 1 stays set while its condition holds (bit 2*m: queue m not empty; bit 2*m+1: queue m not full).
- R9: Writing ones to offset 0x108 + 0x10*u sets those enable bits of user u, writing ones to offset 0x10C + 0x10*u clears them, and a read of either offset returns the current enables.
- R10: Interrupt output irq[u] is high exactly when user u has a status bit that is also enabled; it follows a status or enable change on the cycle after the write.
- R11: Read data appears on bus_rdata on the clock cycle after the read request and stays until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access request for this cycle |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| irq | output | NUM_U | One interrupt line per user |

## Verification
The assertions assume that each bus request addresses a single word-aligned register, that a queue sees at most one write or read per cycle (the bus carries one access per cycle), and that the parameters keep 2*NUM_Q within the 32-bit status word and DEPTH at two or more. The stimulus issues one access at a time through write and read tasks, uses only aligned offsets from the register map, and stays within the default four queues and two users, while still driving full and empty queues on purpose to reach the drop and empty-read cases.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int WORD_W = 32;

  // Address regions selected by byte address bits [8:6]
  localparam logic [2:0] RGN_ID    = 3'd0;
  localparam logic [2:0] RGN_MSG   = 3'd1;
  localparam logic [2:0] RGN_FULL  = 3'd2;
  localparam logic [2:0] RGN_COUNT = 3'd3;

  // Sub-register within a user block, byte address bits [3:2]
  typedef enum logic [1:0] {
    USR_NONE = 2'd0,
    USR_STAT = 2'd1,
    USR_ENSET = 2'd2,
    USR_ENCLR = 2'd3
  } usr_reg_e;
endpackage

// File: rtl/mbx_queue.sv
module mbx_queue #(
  parameter int DEPTH = 4,
  parameter int DW = 32,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    head,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty,
  output logic             push_ok,
  output logic             nf_evt
);
  logic [DW-1:0]    mem [DEPTH];
  logic [PTR_W-1:0] wptr, wptr_n, rptr, rptr_n;
  logic [CNT_W-1:0] cnt_n;
  logic             pop_ok;

  assign full    = (count == CNT_W'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push & ~full;
  assign pop_ok  = pop & ~empty;
  assign nf_evt  = pop_ok & full;
  assign head    = empty ? '0 : mem[rptr];

  always_comb begin
    wptr_n = wptr;
    rptr_n = rptr;
    cnt_n  = count;
    if (push_ok) begin
      wptr_n = (wptr == PTR_W'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      cnt_n  = count + 1'b1;
    end
    if (pop_ok) begin
      rptr_n = (rptr == PTR_W'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      cnt_n  = count - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      wptr  <= wptr_n;
      rptr  <= rptr_n;
      count <= cnt_n;
    end
  end

  // Storage carries no reset; written only when an entry is accepted
  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= wdata;
  end

  // R5
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));
  // R5
  drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> (count == $past(count)));
  // R2
  pop_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !empty && !push) |=> (count == $past(count) - 1'b1));
  // R5
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> (count == '0));
endmodule

// File: rtl/mbx_user_irq.sv
module mbx_user_irq #(
  parameter int EVW = 8,
  parameter int DW = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [EVW-1:0] evt,
  input  logic [EVW-1:0] level,
  input  logic           wr_stat,
  input  logic           wr_enset,
  input  logic           wr_enclr,
  input  logic [DW-1:0]  wdata,
  output logic [EVW-1:0] status,
  output logic [EVW-1:0] enable,
  output logic           irq
);
  logic [EVW-1:0] stat_n, en_n, clr_mask;

  assign clr_mask = wr_stat ? wdata[EVW-1:0] : '0;

  always_comb begin
    stat_n = (status & ~(clr_mask & ~level)) | evt;
    en_n   = enable;
    if (wr_enset)      en_n = enable | wdata[EVW-1:0];
    else if (wr_enclr) en_n = enable & ~wdata[EVW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
      enable <= '0;
    end else begin
      status <= stat_n;
      enable <= en_n;
    end
  end

  assign irq = |(status & enable);

  // R10
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable == '0) |-> !irq);
  // R6
  evt_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((status & $past(evt)) == $past(evt)));
  // R10
  evt_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (((evt & enable) != '0) && !wr_enclr) |=> irq);
  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && ((status & level) != '0)) |=> ((status & $past(status & level)) != '0));
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
  import mbx_pkg::*;
#(
  parameter int          NUM_Q  = 4,
  parameter int          NUM_U  = 2,
  parameter int          DEPTH  = 4,
  parameter int          ADDR_W = 9,
  parameter logic [31:0] REV_ID = 32'h4D42_0100,
  localparam int         EVW    = 2 * NUM_Q,
  localparam int         CNT_W  = $clog2(DEPTH + 1),
  localparam int         QI_W   = (NUM_Q > 1) ? $clog2(NUM_Q) : 1,
  localparam int         UI_W   = (NUM_U > 1) ? $clog2(NUM_U) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [NUM_U-1:0]  irq
);
  logic              acc, rd_acc, wr_acc;
  logic [2:0]        region;
  logic [3:0]        qfield, ufield;
  logic              q_hit, u_hit, user_area;
  logic [QI_W-1:0]   qi;
  logic [UI_W-1:0]   ui;
  usr_reg_e          usub;
  logic [31:0]       rd_n;

  logic [31:0]       q_head  [NUM_Q];
  logic [CNT_W-1:0]  q_cnt   [NUM_Q];
  logic [NUM_Q-1:0]  q_full, q_empty, q_push, q_pop, q_pok, q_nf;
  logic [EVW-1:0]    evt, level;
  logic [EVW-1:0]    u_stat  [NUM_U];
  logic [EVW-1:0]    u_en    [NUM_U];
  logic [NUM_U-1:0]  u_wstat, u_wset, u_wclr;

  // Address decode
  assign acc       = bus_sel & (bus_addr[1:0] == 2'b00);
  assign rd_acc    = acc & ~bus_wr;
  assign wr_acc    = acc & bus_wr;
  assign region    = bus_addr[8:6];
  assign user_area = bus_addr[8];
  assign qfield    = bus_addr[5:2];
  assign ufield    = bus_addr[7:4];
  assign q_hit     = !user_area && (int'(qfield) < NUM_Q);
  assign u_hit     = user_area && (int'(ufield) < NUM_U);
  assign qi        = qfield[QI_W-1:0];
  assign ui        = ufield[UI_W-1:0];
  assign usub      = usr_reg_e'(bus_addr[3:2]);

  // Queues
  for (genvar i = 0; i < NUM_Q; i++) begin : g_q
    assign q_push[i] = wr_acc & q_hit & (region == RGN_MSG) & (qi == QI_W'(i));
    assign q_pop[i]  = rd_acc & q_hit & (region == RGN_MSG) & (qi == QI_W'(i));

    mbx_queue #(.DEPTH(DEPTH), .DW(WORD_W)) u_queue (
      .clk     (clk),
      .rst_n   (rst_n),
      .push    (q_push[i]),
      .pop     (q_pop[i]),
      .wdata   (bus_wdata),
      .head    (q_head[i]),
      .count   (q_cnt[i]),
      .full    (q_full[i]),
      .empty   (q_empty[i]),
      .push_ok (q_pok[i]),
      .nf_evt  (q_nf[i])
    );

    assign evt[2*i]     = q_pok[i];
    assign evt[2*i+1]   = q_nf[i];
    assign level[2*i]   = ~q_empty[i];
    assign level[2*i+1] = ~q_full[i];
  end

  // Per-user status, enable and interrupt line
  for (genvar u = 0; u < NUM_U; u++) begin : g_u
    assign u_wstat[u] = wr_acc & u_hit & (ui == UI_W'(u)) & (usub == USR_STAT);
    assign u_wset[u]  = wr_acc & u_hit & (ui == UI_W'(u)) & (usub == USR_ENSET);
    assign u_wclr[u]  = wr_acc & u_hit & (ui == UI_W'(u)) & (usub == USR_ENCLR);

    mbx_user_irq #(.EVW(EVW), .DW(WORD_W)) u_user (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt      (evt),
      .level    (level),
      .wr_stat  (u_wstat[u]),
      .wr_enset (u_wset[u]),
      .wr_enclr (u_wclr[u]),
      .wdata    (bus_wdata),
      .status   (u_stat[u]),
      .enable   (u_en[u]),
      .irq      (irq[u])
    );
  end

  // Read multiplexer
  always_comb begin
    rd_n = '0;
    if (user_area) begin
      if (u_hit) begin
        unique case (usub)
          USR_STAT:             rd_n = 32'(u_stat[ui]);
          USR_ENSET, USR_ENCLR: rd_n = 32'(u_en[ui]);
          default:              rd_n = '0;
        endcase
      end
    end else begin
      unique case (region)
        RGN_ID:    rd_n = (qfield == '0) ? REV_ID : '0;
        RGN_MSG:   rd_n = q_hit ? q_head[qi] : '0;
        RGN_FULL:  rd_n = q_hit ? 32'(q_full[qi]) : '0;
        RGN_COUNT: rd_n = q_hit ? 32'(q_cnt[qi]) : '0;
        default:   rd_n = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (rd_acc) bus_rdata <= rd_n;
  end

  // R2
  one_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({q_push, q_pop}));
  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_acc |=> $stable(bus_rdata));
endmodule

// File: tb/ipc_mailbox_test.sv
`timescale 1ns/1ps
module ipc_mailbox_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [8:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [1:0]  irq;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  ipc_mailbox uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  function automatic logic [8:0] a_msg(int m);   return 9'(32'h40 + 4*m); endfunction
  function automatic logic [8:0] a_full(int m);  return 9'(32'h80 + 4*m); endfunction
  function automatic logic [8:0] a_cnt(int m);   return 9'(32'hC0 + 4*m); endfunction
  function automatic logic [8:0] a_stat(int u);  return 9'(32'h104 + 16*u); endfunction
  function automatic logic [8:0] a_enset(int u); return 9'(32'h108 + 16*u); endfunction
  function automatic logic [8:0] a_enclr(int u); return 9'(32'h10C + 16*u); endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [8:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(logic [8:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(9'h000, d); check("R1 revision", d, 32'h4D42_0100);
    rd(a_cnt(0), d); check("R4 reset count", d, 0);
    rd(a_full(3), d); check("R3 reset full", d, 0);
    rd(a_stat(1), d); check("R8 reset status", d, 0);
    check("R10 reset irq", 32'(irq), 0);
  endtask

  task automatic t_order();
    logic [31:0] d;
    wr(a_msg(1), 32'hA1); wr(a_msg(1), 32'hB2); wr(a_msg(1), 32'hC3);
    rd(a_cnt(1), d); check("R4 count after three", d, 3);
    rd(a_stat(0), d); check("R6 user0 newmsg q1", d, 32'h04);
    rd(a_stat(1), d); check("R6 user1 newmsg q1", d, 32'h04);
    check("R10 no enable no irq", 32'(irq), 0);
    rd(a_msg(1), d); check("R2 first out", d, 32'hA1);
    rd(a_msg(1), d); check("R2 second out", d, 32'hB2);
    // R11: a non-read cycle keeps the last read value
    @(negedge clk); check("R11 rdata held", bus_rdata, 32'hB2);
    rd(a_msg(1), d); check("R2 third out", d, 32'hC3);
    rd(a_cnt(1), d); check("R4 count drained", d, 0);
  endtask

  task automatic t_full();
    logic [31:0] d;
    for (int k = 0; k < 4; k++) wr(a_msg(0), 32'h100 + k);
    rd(a_full(0), d); check("R3 full set", d, 1);
    wr(a_msg(0), 32'hDEAD);
    rd(a_cnt(0), d); check("R5 drop keeps count", d, 4);
    rd(a_stat(1), d); check("R7 no notfull yet", d & 32'h2, 0);
    rd(a_msg(0), d); check("R2 full queue head", d, 32'h100);
    rd(a_full(0), d); check("R3 full cleared", d, 0);
    rd(a_stat(0), d); check("R7 user0 notfull", d & 32'h2, 32'h2);
    rd(a_stat(1), d); check("R7 user1 notfull", d & 32'h2, 32'h2);
    for (int k = 1; k < 4; k++) begin
      rd(a_msg(0), d); check("R5 dropped entry absent", d, 32'h100 + k);
    end
    rd(a_msg(0), d); check("R5 empty read zero", d, 0);
    rd(a_cnt(0), d); check("R5 empty read count", d, 0);
  endtask

  task automatic t_ack();
    logic [31:0] d;
    rd(a_stat(0), d); check("R8 before ack", d, 32'h07);
    wr(a_stat(0), 32'h0);
    rd(a_stat(0), d); check("R8 zero write no change", d, 32'h07);
    wr(a_stat(0), 32'h5);
    rd(a_stat(0), d); check("R8 clear newmsg bits", d, 32'h02);
    wr(a_stat(0), 32'h2);
    rd(a_stat(0), d); check("R8 notfull held while not full", d, 32'h02);
    rd(a_stat(1), d); check("R8 other user untouched", d, 32'h07);
    wr(a_msg(2), 32'h77);
    wr(a_stat(0), 32'h10);
    rd(a_stat(0), d); check("R8 newmsg held while nonempty", d, 32'h12);
    rd(a_msg(2), d); check("R2 q2 value", d, 32'h77);
    wr(a_stat(0), 32'h10);
    rd(a_stat(0), d); check("R8 newmsg cleared when empty", d, 32'h02);
  endtask

  task automatic t_enable();
    logic [31:0] d;
    wr(a_enset(1), 32'h10);
    check("R10 irq1 on enable", 32'(irq), 32'h2);
    rd(a_enset(1), d); check("R9 enable read set reg", d, 32'h10);
    rd(a_enclr(1), d); check("R9 enable read clr reg", d, 32'h10);
    wr(a_enset(1), 32'h01);
    rd(a_enset(1), d); check("R9 set accumulates", d, 32'h11);
    wr(a_enclr(1), 32'h10);
    rd(a_enset(1), d); check("R9 clear one bit", d, 32'h01);
    check("R10 irq1 after clear", 32'(irq), 32'h2);
    wr(a_enclr(1), 32'h01);
    check("R10 irq1 low", 32'(irq), 0);
    wr(a_enset(0), 32'h40);
    check("R10 enable without status", 32'(irq), 0);
    wr(a_msg(3), 32'h33);
    check("R10 irq0 on new msg", 32'(irq), 32'h1);
    wr(a_stat(0), 32'h40);
    check("R10 irq0 held while nonempty", 32'(irq), 32'h1);
    rd(a_msg(3), d);
    wr(a_stat(0), 32'h40);
    check("R10 irq0 low after ack", 32'(irq), 0);
  endtask

  initial begin
    bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_order();
    t_full();
    t_ack();
    t_enable();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000) begin
      n_chk++;
      n_fail++;
      $display("FAIL R11 watchdog: actual %0d cycles expected fewer", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule